// File: doc/BRIEF.md
# Soft-Start Duty Ramp Sequencer

This block computes the drive duty that a three-phase sinusoidal motor controller applies to its output stage. When a run request arrives it first parks the rotor: it holds a preset alignment duty, which is either one fixed level or a short staircase of three levels, for a selectable alignment time. The commanded duty plays no part in this phase. It then releases the rotor at a fixed launch duty and moves the duty toward the commanded target one 0.01 % unit per slope tick. This gives a constant slew of about 26 %/s with the default tick. While the motor is still starting, the duty always climbs to 20 % before it settles toward a lower command.

The commanded target is sampled only when the rotation feedback signal rises, so the duty follows the speed loop at a pace set by rotation. Thermal and current-limit events force the duty down at once, and recovery uses the normal slope. While current limiting is active, a newly sampled command below the present duty is applied immediately. Supply faults freeze the sequencer and disable the outputs until they clear. The sine modulator and the gate drive stages downstream use `duty_o` and `out_en`.

Top module: `duty_ramp_seq`

## Requirements
- R1: After reset, and while `run_req` is low, `duty_o` is 0, `aligning` is 0 and `out_en` is 0. Feedback edges and target changes in this state have no effect.
- R2: One cycle after `run_req` is seen high in the idle state, `aligning` and `out_en` go high. Alignment lasts exactly ALIGN_SHORT cycles when `align_long` is 0, and ALIGN_LONG cycles when it is 1. The select is captured at the start of alignment.
- R3: During alignment, `duty_o` is 5000 when `align_single` is 1. When it is 0, `duty_o` is 600 for the first ALIGN_STEP1 cycles, 500 for the next ALIGN_STEP2 cycles and 2000 for the rest of alignment.
- R4: In the cycle after alignment ends, `aligning` is 0 and `duty_o` is 1500 for the three-level mode or 2500 for the single-level mode.
- R5: In the run phase with no fault, `duty_o` changes by exactly one unit every TICK_CYC cycles toward the goal, and stays constant once it reaches the goal.
- R6: Until the duty has reached 2000 in the current run, the goal is the larger of the sampled target and 2000. After that, the goal is the sampled target.
- R7: The target is sampled only on a rising edge of `fg`, and is cleared to 0 on each new start. Values above 10000 are sampled as 10000. A falling edge, a steady level, or a target change with no rising edge leaves the goal unchanged.
- R8: While `thermal_flt` is high in the run phase, `duty_o` is min(duty, 1500) from the next cycle on. After it clears, the first step comes TICK_CYC cycles later.
- R9: At the onset of `ilim_flt` in the run phase, the duty drops to min(duty, 1500). While `ilim_flt` stays high, the duty never rises, and a sampled target below the duty is applied in the following cycle with no slope.
- R10: While `ovp_flt` or `uvp_flt` is high, `out_en` is 0 from the next cycle and the duty and phase are frozen. `out_en` returns one cycle after the fault clears, and the ramp continues.
- R11: When `run_req` falls, the next cycle is idle: `duty_o` is 0, and `aligning` and `out_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Run request; low returns the block to idle |
| align_single | input | 1 | 1: single 50 % alignment level; 0: three-level staircase |
| align_long | input | 1 | 1: long alignment time; 0: short |
| fg | input | 1 | Rotation feedback; the rising edge samples the target |
| target_duty | input | 14 | Commanded duty in 0.01 % units |
| thermal_flt | input | 1 | Over-temperature event |
| ilim_flt | input | 1 | Current-limit event |
| ovp_flt | input | 1 | Supply over-voltage |
| uvp_flt | input | 1 | Supply under-voltage |
| duty_o | output | 14 | Present drive duty in 0.01 % units |
| aligning | output | 1 | High during rotor alignment |
| out_en | output | 1 | Output stage enable |

## Verification
The alignment staircase and the launch level are compared cycle by cycle for both alignment modes and both lengths. This tells a wrong step boundary apart from a wrong length. A start with no sampled target is followed over 2400 cycles against the closed-form climb to 20 % and the fall that follows, which exposes errors in tick phase, floor handling and slope sign. Windows of a whole number of ticks check the rate in both directions without depending on tick phase. Feedback pulses with targets above full scale, held high, or sent while idle separate correct edge sampling from level sampling and from stale targets. Snap, jump and freeze stimuli under each fault distinguish "drop to minimum" from "apply the command" and from "hold".

// File: rtl/duty_seq_pkg.sv
package duty_seq_pkg;

  localparam int DUTY_W = 14;
  typedef logic [DUTY_W-1:0] duty_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ALIGN = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  localparam duty_t FULL_SCALE = 14'd10000;

  // Limit a commanded duty to 100 %.
  function automatic duty_t clamp_full(input duty_t d);
    return (d > FULL_SCALE) ? FULL_SCALE : d;
  endfunction

  // Goal used by the slope: the start-up floor applies until first reached.
  function automatic duty_t ramp_goal(input duty_t tgt, input logic floor_done,
                                      input duty_t floor_lvl);
    if (!floor_done && (tgt < floor_lvl)) return floor_lvl;
    return tgt;
  endfunction

  // One unit toward the goal.
  function automatic duty_t slew_once(input duty_t cur, input duty_t goal);
    if (cur < goal) return cur + 1'b1;
    if (cur > goal) return cur - 1'b1;
    return cur;
  endfunction

  // Protection snap: go down to the floor level, never up.
  function automatic duty_t snap_level(input duty_t cur, input duty_t lo);
    return (cur < lo) ? cur : lo;
  endfunction

  // Alignment level as a function of elapsed alignment cycles.
  function automatic duty_t align_level(input logic single, input logic [31:0] t,
                                        input logic [31:0] s1, input logic [31:0] s2,
                                        input duty_t l1, input duty_t l2,
                                        input duty_t l3, input duty_t lb);
    if (single) return lb;
    if (t < s1) return l1;
    if (t < s1 + s2) return l2;
    return l3;
  endfunction

endpackage

// File: rtl/fg_target_latch.sv
module fg_target_latch
  import duty_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  fg,
  input  duty_t target_in,
  output duty_t target_q
);

  logic fg_q;
  logic fg_rise;

  assign fg_rise = fg & ~fg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fg_q     <= 1'b0;
      target_q <= '0;
    end else begin
      fg_q <= fg;
      if (clear)        target_q <= '0;
      else if (fg_rise) target_q <= clamp_full(target_in);
    end
  end

endmodule

// File: rtl/align_sequencer.sv
module align_sequencer
  import duty_seq_pkg::*;
#(
  parameter int    ALIGN_SHORT = 8000000,
  parameter int    ALIGN_LONG  = 10000000,
  parameter int    ALIGN_STEP1 = 600000,
  parameter int    ALIGN_STEP2 = 600000,
  parameter duty_t LVL_A1      = 14'd600,
  parameter duty_t LVL_A2      = 14'd500,
  parameter duty_t LVL_A3      = 14'd2000,
  parameter duty_t LVL_B       = 14'd5000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  advance,
  input  logic  long_sel,
  input  logic  single_sel,
  output duty_t level,
  output logic  done,
  output logic  mode_q
);

  localparam int TMR_W = $clog2(ALIGN_LONG + 1);
  localparam logic [TMR_W-1:0] LAST_S = TMR_W'(ALIGN_SHORT - 1);
  localparam logic [TMR_W-1:0] LAST_L = TMR_W'(ALIGN_LONG - 1);

  logic [TMR_W-1:0] tmr;
  logic             long_q;

  assign done  = advance && (tmr == (long_q ? LAST_L : LAST_S));
  assign level = align_level(mode_q, 32'(tmr), 32'(ALIGN_STEP1), 32'(ALIGN_STEP2),
                             LVL_A1, LVL_A2, LVL_A3, LVL_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr    <= '0;
      long_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (start) begin
      tmr    <= '0;
      long_q <= long_sel;
      mode_q <= single_sel;
    end else if (advance && !done) begin
      tmr <= tmr + 1'b1;
    end
  end

endmodule

// File: rtl/slope_ticker.sv
module slope_ticker #(
  parameter int TICK_CYC = 3846
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);

  localparam int CW = $clog2(TICK_CYC);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = enable && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (enable) cnt <= tick ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/duty_ramp_seq.sv
module duty_ramp_seq
  import duty_seq_pkg::*;
#(
  parameter int    TICK_CYC    = 3846,
  parameter int    ALIGN_SHORT = 8000000,
  parameter int    ALIGN_LONG  = 10000000,
  parameter int    ALIGN_STEP1 = 600000,
  parameter int    ALIGN_STEP2 = 600000,
  parameter duty_t LVL_A1      = 14'd600,
  parameter duty_t LVL_A2      = 14'd500,
  parameter duty_t LVL_A3      = 14'd2000,
  parameter duty_t LVL_B       = 14'd5000,
  parameter duty_t START_A     = 14'd1500,
  parameter duty_t START_B     = 14'd2500,
  parameter duty_t FLOOR_DUTY  = 14'd2000,
  parameter duty_t MIN_DUTY    = 14'd1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              align_single,
  input  logic              align_long,
  input  logic              fg,
  input  logic [DUTY_W-1:0] target_duty,
  input  logic              thermal_flt,
  input  logic              ilim_flt,
  input  logic              ovp_flt,
  input  logic              uvp_flt,
  output logic [DUTY_W-1:0] duty_o,
  output logic              aligning,
  output logic              out_en
);

  phase_t phase, phase_n;
  duty_t  duty_r, duty_n;
  duty_t  tgt_q, align_lvl, goal_w;
  logic   floor_done, ilim_q, out_en_r;

  // Named internal events (used by the bound checker).
  logic supply_w, run_w, start_w, align_adv_w, align_done_w, mode_q;
  logic ilim_onset_w, active_w, snap_w, jump_w, tick_w;

  assign supply_w     = ovp_flt | uvp_flt;
  assign run_w        = (phase == PH_RUN);
  assign start_w      = (phase == PH_IDLE) && run_req;
  assign align_adv_w  = (phase == PH_ALIGN) && run_req && !supply_w;
  assign ilim_onset_w = ilim_flt & ~ilim_q;
  assign active_w     = run_w && run_req && !supply_w;
  assign snap_w       = active_w && (thermal_flt || ilim_onset_w);
  assign jump_w       = active_w && !thermal_flt && ilim_flt && !ilim_onset_w && (tgt_q < duty_r);
  assign goal_w       = ramp_goal(tgt_q, floor_done, FLOOR_DUTY);

  fg_target_latch u_tgt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (phase == PH_IDLE),
    .fg       (fg),
    .target_in(target_duty),
    .target_q (tgt_q)
  );

  align_sequencer #(
    .ALIGN_SHORT(ALIGN_SHORT),
    .ALIGN_LONG (ALIGN_LONG),
    .ALIGN_STEP1(ALIGN_STEP1),
    .ALIGN_STEP2(ALIGN_STEP2),
    .LVL_A1     (LVL_A1),
    .LVL_A2     (LVL_A2),
    .LVL_A3     (LVL_A3),
    .LVL_B      (LVL_B)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .advance   (align_adv_w),
    .long_sel  (align_long),
    .single_sel(align_single),
    .level     (align_lvl),
    .done      (align_done_w),
    .mode_q    (mode_q)
  );

  slope_ticker #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!run_w || thermal_flt || ilim_flt),
    .enable(run_w && !supply_w),
    .tick  (tick_w)
  );

  always_comb begin
    phase_n = phase;
    if (!run_req) begin
      phase_n = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:  phase_n = PH_ALIGN;
        PH_ALIGN: if (align_done_w) phase_n = PH_RUN;
        default:  phase_n = phase;
      endcase
    end
  end

  always_comb begin
    duty_n = duty_r;
    if (!run_req || (phase == PH_IDLE)) begin
      duty_n = '0;
    end else if (phase == PH_ALIGN) begin
      duty_n = align_done_w ? (mode_q ? START_B : START_A) : '0;
    end else if (snap_w) begin
      duty_n = snap_level(duty_r, MIN_DUTY);
    end else if (jump_w) begin
      duty_n = tgt_q;
    end else if (tick_w) begin
      duty_n = slew_once(duty_r, goal_w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      duty_r     <= '0;
      floor_done <= 1'b0;
      ilim_q     <= 1'b0;
      out_en_r   <= 1'b0;
    end else begin
      phase      <= phase_n;
      duty_r     <= duty_n;
      floor_done <= run_w && run_req && (floor_done || (duty_r >= FLOOR_DUTY));
      ilim_q     <= ilim_flt;
      out_en_r   <= (phase_n != PH_IDLE) && !supply_w;
    end
  end

  assign duty_o   = (phase == PH_ALIGN) ? align_lvl : duty_r;
  assign aligning = (phase == PH_ALIGN);
  assign out_en   = out_en_r;

endmodule

// File: rtl/duty_ramp_chk.sv
module duty_ramp_chk
  import duty_seq_pkg::*;
#(
  parameter duty_t LVL_A1   = 14'd600,
  parameter duty_t LVL_A2   = 14'd500,
  parameter duty_t LVL_A3   = 14'd2000,
  parameter duty_t LVL_B    = 14'd5000,
  parameter duty_t START_A  = 14'd1500,
  parameter duty_t START_B  = 14'd2500,
  parameter duty_t MIN_DUTY = 14'd1500
) (
  input logic  clk,
  input logic  rst_n,
  input logic  run_req,
  input logic  thermal_flt,
  input logic  ilim_flt,
  input logic  ovp_flt,
  input logic  uvp_flt,
  input duty_t duty_o,
  input logic  aligning,
  input logic  out_en,
  input logic  run_w,
  input logic  tick_w,
  input logic  snap_w,
  input logic  jump_w,
  input logic  align_done_w,
  input logic  mode_q
);

  a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |=> (duty_o == '0 && !aligning && !out_en));

  a_r10_supply_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_flt || uvp_flt) |=> !out_en);

  a_r10_supply_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && run_req && (ovp_flt || uvp_flt)) |=> $stable(duty_o));

  a_r3_align_levels: assert property (@(posedge clk) disable iff (!rst_n)
    aligning |-> (mode_q ? (duty_o == LVL_B)
                         : (duty_o == LVL_A1 || duty_o == LVL_A2 || duty_o == LVL_A3)));

  a_r4_launch_level: assert property (@(posedge clk) disable iff (!rst_n)
    align_done_w |=> (!aligning && duty_o == (mode_q ? START_B : START_A)));

  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && run_req && !tick_w && !snap_w && !jump_w) |=> $stable(duty_o));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && run_req && tick_w && !snap_w && !jump_w) |=>
      ($stable(duty_o) || duty_o == $past(duty_o) + 1'b1 || duty_o == $past(duty_o) - 1'b1));

  a_r8_thermal_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && run_req && thermal_flt && !ovp_flt && !uvp_flt) |=> (duty_o <= MIN_DUTY));

  a_r9_ilim_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && run_req && ilim_flt && !ovp_flt && !uvp_flt) |=> (duty_o <= $past(duty_o)));

endmodule

bind duty_ramp_seq duty_ramp_chk #(
  .LVL_A1  (LVL_A1),
  .LVL_A2  (LVL_A2),
  .LVL_A3  (LVL_A3),
  .LVL_B   (LVL_B),
  .START_A (START_A),
  .START_B (START_B),
  .MIN_DUTY(MIN_DUTY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_req     (run_req),
  .thermal_flt (thermal_flt),
  .ilim_flt    (ilim_flt),
  .ovp_flt     (ovp_flt),
  .uvp_flt     (uvp_flt),
  .duty_o      (duty_o),
  .aligning    (aligning),
  .out_en      (out_en),
  .run_w       (run_w),
  .tick_w      (tick_w),
  .snap_w      (snap_w),
  .jump_w      (jump_w),
  .align_done_w(align_done_w),
  .mode_q      (mode_q)
);

// File: tb/tb_duty_ramp_seq.sv
module tb_duty_ramp_seq;

  localparam int TICK  = 4;
  localparam int SHORT = 40;
  localparam int LONG  = 50;
  localparam int S1    = 6;
  localparam int S2    = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_req = 1'b0;
  logic        align_single = 1'b0;
  logic        align_long = 1'b0;
  logic        fg = 1'b0;
  logic [13:0] target = '0;
  logic        thermal = 1'b0;
  logic        ilim = 1'b0;
  logic        ovp = 1'b0;
  logic        uvp = 1'b0;
  logic [13:0] duty;
  logic        aligning;
  logic        out_en;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  duty_ramp_seq #(
    .TICK_CYC   (TICK),
    .ALIGN_SHORT(SHORT),
    .ALIGN_LONG (LONG),
    .ALIGN_STEP1(S1),
    .ALIGN_STEP2(S2)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req     (run_req),
    .align_single(align_single),
    .align_long  (align_long),
    .fg          (fg),
    .target_duty (target),
    .thermal_flt (thermal),
    .ilim_flt    (ilim),
    .ovp_flt     (ovp),
    .uvp_flt     (uvp),
    .duty_o      (duty),
    .aligning    (aligning),
    .out_en      (out_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_align(input bit single, input int t);
    if (single) return 5000;
    if (t < S1) return 600;
    if (t < S1 + S2) return 500;
    return 2000;
  endfunction

  task automatic pulse_fg(input int val);
    target = 14'(val);
    fg = 1'b1;
    step(1);
    fg = 1'b0;
  endtask

  // Starts a run and checks every alignment cycle plus the launch cycle.
  task automatic run_align(input bit single, input bit lng);
    int len;
    len = lng ? LONG : SHORT;
    align_single = single;
    align_long   = lng;
    run_req      = 1'b1;
    for (int n = 1; n <= len; n++) begin
      step(1);
      check("R3 alignment level", int'(duty), exp_align(single, n - 1));
      check("R2 aligning flag", int'(aligning), 1);
      check("R2 enable during alignment", int'(out_en), 1);
    end
    step(1);
    check("R2 alignment length", int'(aligning), 0);
    check("R4 launch duty", int'(duty), single ? 2500 : 1500);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d1;
    int d2;
    int e;
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 reset duty", int'(duty), 0);
    check("R1 reset aligning", int'(aligning), 0);
    check("R1 reset enable", int'(out_en), 0);
    pulse_fg(4000);
    step(2);
    check("R1 idle ignores fg", int'(duty), 0);
    check("R1 idle enable", int'(out_en), 0);

    // Three-level short alignment, no sampled target: climb to floor, then fall.
    target = 14'd3000;
    run_align(1'b0, 1'b0);
    for (int m = 0; m <= 2400; m++) begin
      if (m > 0) step(1);
      if (m <= 2000)     e = 1500 + m / TICK;
      else if (m < 2004) e = 2000;
      else               e = 2000 - (m - 2000) / TICK;
      check("R6 floor climb then fall (R7 no edge)", int'(duty), e);
    end

    pulse_fg(3000);
    step(3);
    d1 = int'(duty);
    step(40);
    check("R5 rise rate", int'(duty), d1 + 10);
    step(5000);
    check("R5 settle at target", int'(duty), 3000);
    step(40);
    check("R5 hold at target", int'(duty), 3000);

    fg = 1'b1;
    step(2);
    target = 14'd5000;
    step(2);
    fg = 1'b0;
    step(40);
    check("R7 level and falling edge ignored", int'(duty), 3000);

    pulse_fg(12000);
    step(7000 * TICK + 200);
    check("R7 clamp to full scale", int'(duty), 10000);

    thermal = 1'b1;
    step(1);
    check("R8 thermal snap", int'(duty), 1500);
    step(20);
    check("R8 thermal hold", int'(duty), 1500);
    thermal = 1'b0;
    step(TICK - 1);
    check("R8 no step before tick", int'(duty), 1500);
    step(1);
    check("R8 first recovery step", int'(duty), 1501);
    step(40);
    check("R8 recovery slope", int'(duty), 1511);

    ilim = 1'b1;
    step(1);
    check("R9 ilim snap", int'(duty), 1500);
    step(10);
    check("R9 ilim no rise", int'(duty), 1500);
    target = 14'd1000;
    fg = 1'b1;
    step(1);
    check("R9 before jump", int'(duty), 1500);
    fg = 1'b0;
    step(1);
    check("R9 jump to command", int'(duty), 1000);
    ilim = 1'b0;
    step(40);
    check("R5 hold at lowered goal", int'(duty), 1000);

    pulse_fg(2000);
    step(20);
    ovp = 1'b1;
    d1 = int'(duty);
    step(1);
    check("R10 ovp disables", int'(out_en), 0);
    for (int k = 0; k < 30; k++) begin
      step(1);
      check("R10 duty frozen", int'(duty), d1);
    end
    ovp = 1'b0;
    step(1);
    check("R10 enable returns", int'(out_en), 1);
    d2 = int'(duty);
    step(40);
    check("R10 ramp resumes", int'(duty), d2 + 10);
    uvp = 1'b1;
    step(1);
    check("R10 uvp disables", int'(out_en), 0);
    uvp = 1'b0;
    step(1);
    check("R10 uvp enable returns", int'(out_en), 1);

    run_req = 1'b0;
    step(1);
    check("R11 stop duty", int'(duty), 0);
    check("R11 stop aligning", int'(aligning), 0);
    check("R11 stop enable", int'(out_en), 0);

    pulse_fg(4000);
    step(3);
    run_align(1'b1, 1'b1);
    step(3);
    check("R7 target cleared at start", int'(duty), 2500);
    step(1);
    check("R7 stale idle edge ignored", int'(duty), 2499);

    run_req = 1'b0;
    step(2);
    run_align(1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule